// File: doc/BRIEF.md
# Matrix-Unit Load and Compute Sequencer

This block is the control state machine of a small matrix-multiply engine built around a 2x2 array. It waits in an idle state until the host raises a load request. It then walks an operand-memory slot address through the eight slots that hold the two 2x2 operand matrices, one slot per clock. Loading and computing overlap. Once the first row and the first column are present (slot address 2), the block raises the array enable. It also starts a step index that paces the products and the result writeback.

After the step index reaches its last value, the block drops the enable, clears the index, and either returns to idle or starts the next load at once if the request is still high. Once a sequence has begun it always runs to completion, and the load request is ignored until the final step. The block has three outputs, all registered: the slot address, the enable and the step index.

Top module: `mxu_seq_top`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the next cycle shows `slot_addr`=0, `mac_en`=0 and `step_idx`=0, including when reset arrives in the middle of a sequence.
- R2: In idle with `load_req` low, all outputs stay at zero for any number of cycles.
- R3: When `load_req` is sampled high in idle, the following cycle shows `slot_addr`=0. The address then rises by one per clock up to 7, so loading takes eight cycles.
- R4: `mac_en` rises in the same cycle that `slot_addr` first shows 2, and `step_idx` shows 1 in that cycle.
- R5: While `mac_en` is high and `step_idx` is below 7, the index rises by one per clock. It shows 2 through 6 alongside addresses 3 through 7. It shows 7 in the following cycle, in which `slot_addr` has returned to 0.
- R6: In the cycle after `step_idx` shows 7, `mac_en` is 0 and `step_idx` is 0.
- R7: Once a sequence has started, the value of `load_req` has no effect on any output until the cycle in which `step_idx` shows 7.
- R8: If `load_req` is high in the cycle in which `step_idx` shows 7, the next cycle is the first load cycle (`slot_addr`=0) of a new sequence. Back-to-back sequences therefore repeat every nine cycles, and 100 of them in a row keep exact timing.
- R9: If `load_req` is low in the cycle in which `step_idx` shows 7, the block returns to idle and its outputs stay at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_req | input | 1 | Request to start a load-and-compute sequence |
| slot_addr | output | 3 | Operand memory slot being loaded |
| mac_en | output | 1 | Enable for the multiply array |
| step_idx | output | 3 | Compute and writeback step index |

## Verification
The sequence is driven with four kinds of request pattern:
- A single request that is dropped right away shows the full nine-cycle shape and the return to idle.
- A request that toggles every cycle during the sequence separates a design that samples the request only in idle or at the final step from one that reacts to it mid-sequence.
- A request held high for 100 sequences shows whether the restart costs an extra idle cycle or slips the enable point.
- Long idle stretches with the request low, and a reset in the middle of loading, show that no state leaks out of idle or survives reset.

// File: rtl/mxu_seq_pkg.sv
// Package: shared types for the matrix-unit sequencer.
// Assumes: nothing; holds only the state encoding.
package mxu_seq_pkg;

    // Sequencer phases: waiting, streaming operands, finishing compute.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_t;

endpackage

// File: rtl/mxu_seq_fsm.sv
// Module: phase state machine of the sequencer.
// Does: moves idle -> load on a request, load -> drain after the last slot,
//       drain -> load or idle after the last compute step.
// Assumes: addr_last and step_last come from registered counters.
module mxu_seq_fsm
    import mxu_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_req,
    input  logic       addr_last,
    input  logic       step_last,
    output seq_state_t state
);

    seq_state_t state_q;
    seq_state_t state_d;

    // Next-phase selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (load_req) begin
                    state_d = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (addr_last) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (step_last) begin
                    state_d = load_req ? ST_LOAD : ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Phase register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/mxu_seq_addr_ctr.sv
// Module: operand slot address counter.
// Does: holds 0 outside loading; during loading steps by one per clock and
//       returns to 0 after the last slot. Flags the last slot and the slot
//       just before the enable point.
// Assumes: EN_ADDR >= 1 and EN_ADDR < N_SLOTS.
module mxu_seq_addr_ctr
    import mxu_seq_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int EN_ADDR = 2,
    parameter int ADDR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state,
    output logic [ADDR_W-1:0] addr,
    output logic              addr_last,
    output logic              addr_arm
);

    localparam logic [ADDR_W-1:0] LAST_SLOT = ADDR_W'(N_SLOTS - 1);
    localparam logic [ADDR_W-1:0] ARM_SLOT  = ADDR_W'(EN_ADDR - 1);

    logic [ADDR_W-1:0] addr_q;
    logic              loading;

    // Loading is active only in the load phase.
    assign loading   = (state == ST_LOAD);
    // Last slot of the operand block is being addressed.
    assign addr_last = loading && (addr_q == LAST_SLOT);
    // Next clock brings the slot at which compute may begin.
    assign addr_arm  = loading && (addr_q == ARM_SLOT);

    // Address register: advance while loading, park at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (loading && !addr_last) begin
            addr_q <= addr_q + 1'b1;
        end else begin
            addr_q <= '0;
        end
    end

    assign addr = addr_q;

endmodule

// File: rtl/mxu_seq_step_ctr.sv
// Module: array enable and compute step counter.
// Does: raises the enable with step 1 on arm, counts one step per clock
//       while enabled, and clears both after the final step.
// Assumes: arm is a single-cycle pulse per sequence; STEP_LAST fits STEP_W.
module mxu_seq_step_ctr #(
    parameter int STEP_LAST = 7,
    parameter int STEP_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    output logic              en,
    output logic [STEP_W-1:0] step,
    output logic              step_last
);

    localparam logic [STEP_W-1:0] FINAL_STEP = STEP_W'(STEP_LAST);

    logic              en_q;
    logic [STEP_W-1:0] step_q;

    // Final compute step reached while enabled.
    assign step_last = en_q && (step_q == FINAL_STEP);

    // Enable and step registers: start, count, then clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            step_q <= '0;
        end else if (arm) begin
            en_q   <= 1'b1;
            step_q <= STEP_W'(1);
        end else if (step_last) begin
            en_q   <= 1'b0;
            step_q <= '0;
        end else if (en_q) begin
            step_q <= step_q + 1'b1;
        end
    end

    assign en   = en_q;
    assign step = step_q;

endmodule

// File: rtl/mxu_seq_top.sv
// Module: matrix-unit load and compute sequencer, top level.
// Does: streams operand slot addresses, raises the array enable once the
//       first row and column are loaded, and paces compute and writeback.
// Assumes: the compute window outlasts loading (STEP_LAST > N_SLOTS-EN_ADDR).
module mxu_seq_top
    import mxu_seq_pkg::*;
#(
    parameter  int N_DIM     = 2,
    parameter  int STEP_LAST = 7,
    localparam int N_SLOTS   = 2 * N_DIM * N_DIM,
    localparam int EN_ADDR   = N_DIM,
    localparam int ADDR_W    = $clog2(N_SLOTS),
    localparam int STEP_W    = $clog2(STEP_LAST + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_req,
    output logic [ADDR_W-1:0] slot_addr,
    output logic              mac_en,
    output logic [STEP_W-1:0] step_idx
);

    // Elaboration guard: compute must end after the last slot is loaded.
    if (STEP_LAST <= N_SLOTS - EN_ADDR) begin : g_bad_window
        $error("STEP_LAST too small for the loading window");
    end

    seq_state_t state;
    logic       addr_last;
    logic       addr_arm;
    logic       step_last;

    mxu_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_req  (load_req),
        .addr_last (addr_last),
        .step_last (step_last),
        .state     (state)
    );

    mxu_seq_addr_ctr #(
        .N_SLOTS (N_SLOTS),
        .EN_ADDR (EN_ADDR),
        .ADDR_W  (ADDR_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .addr      (slot_addr),
        .addr_last (addr_last),
        .addr_arm  (addr_arm)
    );

    mxu_seq_step_ctr #(
        .STEP_LAST (STEP_LAST),
        .STEP_W    (STEP_W)
    ) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (addr_arm),
        .en        (mac_en),
        .step      (step_idx),
        .step_last (step_last)
    );

endmodule

// File: rtl/mxu_seq_chk.sv
// Module: property checker for the sequencer, bound to mxu_seq_top.
// Does: checks reset, idle, address stepping, enable point and step timing.
// Assumes: state is the top-level phase signal.
module mxu_seq_chk
    import mxu_seq_pkg::*;
#(
    parameter int ADDR_W    = 3,
    parameter int STEP_W    = 3,
    parameter int N_SLOTS   = 8,
    parameter int EN_ADDR   = 2,
    parameter int STEP_LAST = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_req,
    input logic [ADDR_W-1:0] slot_addr,
    input logic              mac_en,
    input logic [STEP_W-1:0] step_idx,
    input seq_state_t        state
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (slot_addr == '0 && !mac_en && step_idx == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !load_req) |=>
            (slot_addr == '0 && !mac_en && step_idx == '0));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD && slot_addr != ADDR_W'(N_SLOTS - 1)) |=>
            (slot_addr == ADDR_W'($past(slot_addr) + 1'b1)));

    // R4
    en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mac_en) |-> (slot_addr == ADDR_W'(EN_ADDR) && step_idx == STEP_W'(1)));

    // R5
    step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_en && step_idx != STEP_W'(STEP_LAST)) |=>
            (mac_en && step_idx == STEP_W'($past(step_idx) + 1'b1)));

    // R6
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_en && step_idx == STEP_W'(STEP_LAST)) |=> (!mac_en && step_idx == '0));

    // R8
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_en && step_idx == STEP_W'(STEP_LAST) && load_req) |=>
            (state == ST_LOAD && slot_addr == '0));

    // R9
    back_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_en && step_idx == STEP_W'(STEP_LAST) && !load_req) |=> (state == ST_IDLE));

endmodule

bind mxu_seq_top mxu_seq_chk #(
    .ADDR_W    (ADDR_W),
    .STEP_W    (STEP_W),
    .N_SLOTS   (N_SLOTS),
    .EN_ADDR   (EN_ADDR),
    .STEP_LAST (STEP_LAST)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_req  (load_req),
    .slot_addr (slot_addr),
    .mac_en    (mac_en),
    .step_idx  (step_idx),
    .state     (state)
);

// File: tb/tb_mxu_seq_top.sv
// Bench: directed scenarios for mxu_seq_top; inputs driven and outputs
// sampled on the falling edge.
module tb_mxu_seq_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_req = 1'b0;
    logic [2:0] slot_addr;
    logic       mac_en;
    logic [2:0] step_idx;

    int n_checks = 0;
    int n_fails  = 0;
    bit reported = 1'b0;

    mxu_seq_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_req  (load_req),
        .slot_addr (slot_addr),
        .mac_en    (mac_en),
        .step_idx  (step_idx)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Print the one summary line and stop.
    task automatic finish_run();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // Compare all three outputs against expected values.
    task automatic expect_out(input string req, input logic [2:0] ea,
                              input logic ee, input logic [2:0] es);
        n_checks++;
        if (slot_addr !== ea || mac_en !== ee || step_idx !== es) begin
            n_fails++;
            $display("FAIL %s: got addr=%0d en=%0d step=%0d, expected addr=%0d en=%0d step=%0d",
                     req, slot_addr, mac_en, step_idx, ea, ee, es);
        end
    endtask

    // Check the nine cycles of one sequence whose start edge just passed.
    // mode 0: request low; 1: toggle every cycle; 2: held high throughout.
    // last_req: request value presented in the final step cycle.
    task automatic run_sequence(input string req, input int mode, input bit last_req);
        for (int k = 1; k <= 9; k++) begin
            logic [2:0] ea;
            logic       ee;
            logic [2:0] es;
            @(negedge clk);
            ea = (k <= 8) ? 3'(k - 1) : 3'd0;
            ee = (k >= 3);
            es = (k >= 3) ? 3'(k - 2) : 3'd0;
            expect_out(req, ea, ee, es);
            if (k == 9)         load_req = last_req;
            else if (mode == 1) load_req = k[0];
            else if (mode == 2) load_req = 1'b1;
            else                load_req = 1'b0;
        end
    endtask

    // R1: reset clears everything, also mid-sequence.
    task automatic t_reset();
        rst_n = 1'b0;
        load_req = 1'b1;
        repeat (3) @(negedge clk);
        expect_out("R1 reset", 3'd0, 1'b0, 3'd0);
        load_req = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        load_req = 1'b1;
        repeat (5) @(negedge clk);
        load_req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        expect_out("R1 mid-sequence reset", 3'd0, 1'b0, 3'd0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 after release", 3'd0, 1'b0, 3'd0);
    endtask

    // R2: long idle with request low.
    task automatic t_idle();
        load_req = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            expect_out("R2 idle", 3'd0, 1'b0, 3'd0);
        end
    endtask

    // R3 R4 R5 R6 R9: one sequence, then return to idle.
    task automatic t_single();
        @(negedge clk);
        load_req = 1'b1;
        run_sequence("R3/R4/R5 single", 0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            expect_out("R6/R9 back to idle", 3'd0, 1'b0, 3'd0);
        end
    endtask

    // R7: request toggling during a sequence changes nothing.
    task automatic t_toggle();
        @(negedge clk);
        load_req = 1'b1;
        run_sequence("R7 toggling request", 1, 1'b0);
        @(negedge clk);
        expect_out("R7 idle after toggled sequence", 3'd0, 1'b0, 3'd0);
    endtask

    // R8: 100 back-to-back sequences with the request held high.
    task automatic t_back_to_back();
        @(negedge clk);
        load_req = 1'b1;
        for (int n = 0; n < 100; n++) begin
            run_sequence("R8 back-to-back", 2, (n != 99));
        end
        @(negedge clk);
        expect_out("R9 idle after burst", 3'd0, 1'b0, 3'd0);
    endtask

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    // Scenario sequence.
    initial begin
        t_reset();
        t_idle();
        t_single();
        t_toggle();
        t_back_to_back();
        t_idle();
        finish_run();
    end

endmodule